// File: doc/BRIEF.md
# Sixty-Four Input Interrupt Router

This block is a platform interrupt controller for 64 interrupt lines. Each line is either level sensitive or edge sensitive. For every line the block tracks four bits of state: pending, in-service, mask and edge mode. When a line becomes due, the block sends an assert event downstream. When a due line is withdrawn, it sends a deassert event. Both kinds of event carry an 8-bit vector, which is taken from a per-line vector table.

Software reaches the block through a 32-bit memory-mapped register port. The port has a write strobe, a read strobe, a byte offset and an error flag on the response. A mask write can change the state of many lines at once, and so can a write-1-to-clear access. Every line such a write touches is re-examined in ascending index order, so one register access may produce a burst of events. The events leave one at a time through a valid/ready handshake.

While any re-examination is still waiting to be serviced, the register port does not accept the next access. Polarity, automatic distribution and route selection are fixed at their default values.

Top module: `irq_router_top`

## Requirements
- R1: Each 64-bit register is reached as two 32-bit halves. Offset bit 2 picks the half: 1 selects bits 63:32 and 0 selects bits 31:0. Writing one half leaves the other half unchanged.
- R2: The accepted byte windows are as follows.
  - Identification 0x00-0x07: read only.
  - Mask 0x20-0x27.
  - Message enable 0x40-0x47.
  - Edge mode 0x60-0x67.
  - Clear 0x80-0x87: write only.
  - Two auto-control registers, 0xC0-0xC7 and 0xE0-0xE7.
  - Route 0x100-0x13F.
  - Vector table 0x200-0x23F.
  - Polarity 0x3E0-0x3E7.

  Any other offset, a read of the clear window, or a write of the identification window sets `reg_err` in the response.
- R3: The identification low half reads 0x07000000. The high half reads 0x001F0001: version 1 sits in bits 15:0 and the value 31 in bits 23:16.
- R4: A rising input sets its pending bit. If the line is unmasked, the block also sets its in-service bit and emits an assert event (`evt_level`=1) that carries the line's vector.
- R5: A falling input in edge mode (edge bit = 1) changes nothing. A falling input in level mode clears its pending bit. If the line is then in service with no pending bit, the block clears in-service and emits a deassert event (`evt_level`=0) with the vector.
- R6: A mask write re-examines every mask bit that changed, in ascending index order. A bit going from 1 to 0 on a pending line emits an assert. A bit going from 0 to 1 on a pending line emits no event.
- R7: A write to the clear window clears only those pending bits that are set, in edge mode and written as 1. Each cleared line then emits a deassert event if it was in service. Level lines are not affected.
- R8: Both auto-control registers and the polarity register read 0 after any write. Route bytes read 0x00000001. Message enable stores and returns what was written.
- R9: A vector-table write stores `reg_wdata[7:0]` at entry (offset - 0x200). A read returns that byte in bits 7:0. After reset, entry i holds i.
- R10: An event held with `evt_ready` low keeps `evt_valid`, `evt_vector` and `evt_level` stable until it is accepted. Events leave in the order given by R4-R7.
- R11: An access is answered by a one-cycle `reg_ready` pulse that carries `reg_rdata`/`reg_err`. No access is answered while re-examinations are outstanding.
- R12: Reset clears pending, in-service, edge mode and message enable, and sets every mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Interrupt input lines |
| reg_wr | input | 1 | Write strobe, held until `reg_ready` |
| reg_rd | input | 1 | Read strobe, held until `reg_ready` |
| reg_addr | input | 10 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with `reg_ready` |
| reg_ready | output | 1 | One-cycle access completion |
| reg_err | output | 1 | Access hit no legal window, valid with `reg_ready` |
| evt_valid | output | 1 | Event present |
| evt_ready | input | 1 | Downstream accepts the event |
| evt_vector | output | 8 | Vector carried by the event |
| evt_level | output | 1 | 1 = assert, 0 = deassert |

## Verification
The bench targets the following corner cases:
- A level line that falls while masked must still deassert; a design that gates deassertion by the mask would leave that line in service forever.
- An edge line that falls must stay pending until a clear write; a design that treats edge lines as level would emit an early deassert.
- A clear write aimed at a level line must be ignored; a design that clears it would emit an early deassert.
- An unmask that releases four pending lines under downstream backpressure must produce four asserts in ascending order; a design that drops the held event or services lines out of order would break this.
- A half write must not disturb the other half.
- A register access issued while events are backed up must stall until the work drains.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic [3:0] {
    WIN_NONE,
    WIN_IDENT,
    WIN_MASK,
    WIN_MSGEN,
    WIN_EDGE,
    WIN_CLEAR,
    WIN_AUTO,
    WIN_ROUTE,
    WIN_VECT,
    WIN_POL
  } win_e;

  // Byte bases of the register windows
  localparam int BASE_IDENT = 'h000;
  localparam int BASE_MASK  = 'h020;
  localparam int BASE_MSGEN = 'h040;
  localparam int BASE_EDGE  = 'h060;
  localparam int BASE_CLEAR = 'h080;
  localparam int BASE_AUTOA = 'h0C0;
  localparam int BASE_AUTOB = 'h0E0;
  localparam int BASE_ROUTE = 'h100;
  localparam int BASE_VECT  = 'h200;
  localparam int BASE_POL   = 'h3E0;
  localparam int WIDE_LEN   = 8;
  localparam int ROUTE_LEN  = 'h40;

  localparam logic [31:0] IDENT_LO = 32'h0700_0000;
  localparam logic [31:0] IDENT_HI = 32'h001F_0001;

endpackage

// File: rtl/irq_router_decode.sv
module irq_router_decode
  import irq_router_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int NUM_IRQ = 64,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic              hi_half,
  output logic [IDX_W-1:0]  vidx
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int base, input int len);
    return (int'(a) >= base) && (int'(a) < base + len);
  endfunction

  always_comb begin
    win = WIN_NONE;
    if      (hit(addr, BASE_IDENT, WIDE_LEN))  win = WIN_IDENT;
    else if (hit(addr, BASE_MASK,  WIDE_LEN))  win = WIN_MASK;
    else if (hit(addr, BASE_MSGEN, WIDE_LEN))  win = WIN_MSGEN;
    else if (hit(addr, BASE_EDGE,  WIDE_LEN))  win = WIN_EDGE;
    else if (hit(addr, BASE_CLEAR, WIDE_LEN))  win = WIN_CLEAR;
    else if (hit(addr, BASE_AUTOA, WIDE_LEN))  win = WIN_AUTO;
    else if (hit(addr, BASE_AUTOB, WIDE_LEN))  win = WIN_AUTO;
    else if (hit(addr, BASE_ROUTE, ROUTE_LEN)) win = WIN_ROUTE;
    else if (hit(addr, BASE_VECT,  NUM_IRQ))   win = WIN_VECT;
    else if (hit(addr, BASE_POL,   WIDE_LEN))  win = WIN_POL;
  end

  assign hi_half = addr[2];
  // The vector window base is aligned to a multiple of NUM_IRQ, so the low bits are the entry
  assign vidx = addr[IDX_W-1:0];

endmodule

// File: rtl/irq_router_lowbit.sv
module irq_router_lowbit #(
  parameter int W      = 64,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign any = |vec;

endmodule

// File: rtl/irq_router_vectab.sv
module irq_router_vectab #(
  parameter int DEPTH  = 64,
  parameter int VEC_W  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [VEC_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr_a,
  output logic [VEC_W-1:0] rdata_a,
  input  logic [IDX_W-1:0] raddr_b,
  output logic [VEC_W-1:0] rdata_b
);

  logic [VEC_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= VEC_W'(i);
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Two asynchronous read ports: service path and register path
  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
#(
  parameter int NUM_IRQ = 64,   // must be 2*DATA_W: each wide register is two halves
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_ready,
  output logic               reg_err,
  output logic               evt_valid,
  input  logic               evt_ready,
  output logic [VEC_W-1:0]   evt_vector,
  output logic               evt_level
);

  localparam int IDX_W  = $clog2(NUM_IRQ);
  localparam int HALVES = NUM_IRQ / DATA_W;

  // State
  logic [NUM_IRQ-1:0] irq_q, irr_q, isr_q, mask_q, edge_q, msgen_q, work_q;
  logic               ack_q, err_q;
  logic [DATA_W-1:0]  rdata_q;

  // Decode
  win_e             win;
  logic             hi_half;
  logic [IDX_W-1:0] vidx;

  irq_router_decode #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) decode_i (
    .addr(reg_addr), .win(win), .hi_half(hi_half), .vidx(vidx)
  );

  // Access acceptance: only with no outstanding work and no response in flight
  logic acc_go, do_wr, do_rd;
  assign acc_go = (reg_wr | reg_rd) & ~ack_q & ~|work_q;
  assign do_wr  = acc_go & reg_wr;
  assign do_rd  = acc_go & ~reg_wr;

  // Half-lane helpers
  logic [NUM_IRQ-1:0] hmask, wfull;
  assign hmask = {{DATA_W{hi_half}}, {DATA_W{~hi_half}}};
  assign wfull = {HALVES{reg_wdata}};

  function automatic logic [DATA_W-1:0] pick_half(input logic [NUM_IRQ-1:0] r, input logic hi);
    return hi ? r[NUM_IRQ-1:DATA_W] : r[DATA_W-1:0];
  endfunction

  logic [NUM_IRQ-1:0] mask_new, mask_chg, clr_vec;
  assign mask_new = (mask_q & ~hmask) | (wfull & hmask);
  assign mask_chg = (do_wr && win == WIN_MASK) ? (mask_q ^ mask_new) : '0;
  assign clr_vec  = (do_wr && win == WIN_CLEAR) ? (irr_q & edge_q & wfull & hmask) : '0;

  // Input edge detection
  logic [NUM_IRQ-1:0] rise, lvl_fall;
  assign rise     = irq_in & ~irq_q;
  assign lvl_fall = ~irq_in & irq_q & ~edge_q;

  // Work service: lowest pending index first
  logic [IDX_W-1:0] svc_idx;
  logic             work_any, svc_go, a_hit, d_hit;

  irq_router_lowbit #(.W(NUM_IRQ)) lowbit_i (
    .vec(work_q), .idx(svc_idx), .any(work_any)
  );

  assign svc_go = work_any & (~evt_valid | evt_ready);
  assign a_hit  = svc_go &  irr_q[svc_idx] & ~mask_q[svc_idx];
  assign d_hit  = svc_go & ~a_hit & isr_q[svc_idx] & ~irr_q[svc_idx];

  // Vector table
  logic [VEC_W-1:0] vec_svc, vec_reg;
  irq_router_vectab #(.DEPTH(NUM_IRQ), .VEC_W(VEC_W)) vectab_i (
    .clk(clk), .rst(rst),
    .we(do_wr && win == WIN_VECT), .waddr(vidx), .wdata(reg_wdata[VEC_W-1:0]),
    .raddr_a(svc_idx), .rdata_a(vec_svc),
    .raddr_b(vidx),    .rdata_b(vec_reg)
  );

  // Response mux
  logic [DATA_W-1:0] rd_val;
  logic              rd_err, wr_err;

  always_comb begin
    rd_val = '0;
    rd_err = 1'b0;
    wr_err = 1'b0;
    unique case (win)
      WIN_IDENT: begin rd_val = hi_half ? IDENT_HI : IDENT_LO; wr_err = 1'b1; end
      WIN_MASK:  rd_val = pick_half(mask_q, hi_half);
      WIN_MSGEN: rd_val = pick_half(msgen_q, hi_half);
      WIN_EDGE:  rd_val = pick_half(edge_q, hi_half);
      WIN_CLEAR: rd_err = 1'b1;
      WIN_AUTO:  rd_val = '0;
      WIN_ROUTE: rd_val = DATA_W'(1);
      WIN_VECT:  rd_val = DATA_W'(vec_reg);
      WIN_POL:   rd_val = '0;
      default:   begin rd_err = 1'b1; wr_err = 1'b1; end
    endcase
  end

  // Next-state terms
  logic [NUM_IRQ-1:0] irr_n, isr_n, work_n, svc_bit;
  always_comb begin
    svc_bit = '0;
    if (svc_go) svc_bit[svc_idx] = 1'b1;
    irr_n  = ((irr_q & ~clr_vec) | rise) & ~lvl_fall;
    isr_n  = isr_q;
    if (a_hit) isr_n[svc_idx] = 1'b1;
    if (d_hit) isr_n[svc_idx] = 1'b0;
    work_n = (work_q & ~svc_bit) | rise | lvl_fall | mask_chg | clr_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q      <= '0;
      irr_q      <= '0;
      isr_q      <= '0;
      mask_q     <= '1;
      edge_q     <= '0;
      msgen_q    <= '0;
      work_q     <= '0;
      ack_q      <= 1'b0;
      err_q      <= 1'b0;
      rdata_q    <= '0;
      evt_valid  <= 1'b0;
      evt_vector <= '0;
      evt_level  <= 1'b0;
    end else begin
      irq_q  <= irq_in;
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      work_q <= work_n;

      if (do_wr && win == WIN_MASK)  mask_q  <= mask_new;
      if (do_wr && win == WIN_EDGE)  edge_q  <= (edge_q & ~hmask) | (wfull & hmask);
      if (do_wr && win == WIN_MSGEN) msgen_q <= (msgen_q & ~hmask) | (wfull & hmask);

      ack_q   <= acc_go;
      err_q   <= acc_go & (reg_wr ? wr_err : rd_err);
      rdata_q <= do_rd ? rd_val : '0;

      if (evt_valid && evt_ready) evt_valid <= 1'b0;
      if (a_hit || d_hit) begin
        evt_valid  <= 1'b1;
        evt_vector <= vec_svc;
        evt_level  <= a_hit;
      end
    end
  end

  assign reg_ready = ack_q;
  assign reg_err   = err_q;
  assign reg_rdata = rdata_q;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_IRQ = 64,
  parameter int VEC_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_ready,
  input logic               reg_err,
  input logic               evt_valid,
  input logic               evt_ready,
  input logic [VEC_W-1:0]   evt_vector,
  input logic               evt_level,
  input logic [NUM_IRQ-1:0] work_q
);

  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_vector) && $stable(evt_level))); // R10

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    reg_ready |=> !reg_ready); // R11

  AST_ACK_STALL: assert property (@(posedge clk) disable iff (rst)
    (work_q != '0) |=> !reg_ready); // R11

  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    reg_err |-> reg_ready); // R2

  AST_EVT_FROM_WORK: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_valid) |-> $past(work_q != '0)); // R4

endmodule

bind irq_router_top irq_router_chk #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst(rst), .reg_ready(reg_ready), .reg_err(reg_err),
  .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_vector(evt_vector),
  .evt_level(evt_level), .work_q(work_q)
);

// File: tb/irq_router_top_tb_top.sv
`timescale 1ns/100ps
module irq_router_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_ready, reg_err;
  logic        evt_valid, evt_level;
  logic        evt_ready = 1'b1;
  logic [7:0]  evt_vector;

  always #2.5 clk = ~clk;

  irq_router_top dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_ready(reg_ready), .reg_err(reg_err), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_vector(evt_vector), .evt_level(evt_level)
  );

  int n_chk = 0, n_bad = 0;
  bit bp_en = 0, hold_low = 0;

  // Behavioural reference state
  bit [63:0] m_irr = '0, m_isr = '0, m_mask = '1, m_edge = '0, m_msgen = '0;
  bit [7:0]  m_vec [64];
  bit [8:0]  exp_q [$];   // {level, vector}

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  function automatic void m_up(input int i);
    if (m_irr[i] && !m_mask[i]) begin
      m_isr[i] = 1'b1;
      exp_q.push_back({1'b1, m_vec[i]});
    end
  endfunction

  function automatic void m_down(input int i);
    if (m_isr[i] && !m_irr[i]) begin
      m_isr[i] = 1'b0;
      exp_q.push_back({1'b0, m_vec[i]});
    end
  endfunction

  function automatic bit [63:0] put_half(input bit [63:0] r, input bit hi, input bit [31:0] d);
    if (hi) return {d, r[31:0]};
    return {r[63:32], d};
  endfunction

  // Expected read response {err, data}
  function automatic bit [32:0] m_read(input int a);
    bit hi = a[2];
    if (a < 8)                     return {1'b0, hi ? 32'h001F0001 : 32'h07000000};
    if (a >= 'h20 && a < 'h28)     return {1'b0, hi ? m_mask[63:32]  : m_mask[31:0]};
    if (a >= 'h40 && a < 'h48)     return {1'b0, hi ? m_msgen[63:32] : m_msgen[31:0]};
    if (a >= 'h60 && a < 'h68)     return {1'b0, hi ? m_edge[63:32]  : m_edge[31:0]};
    if ((a >= 'hC0 && a < 'hC8) || (a >= 'hE0 && a < 'hE8) || (a >= 'h3E0 && a < 'h3E8))
      return 33'h0;
    if (a >= 'h100 && a < 'h140)   return 33'h1;
    if (a >= 'h200 && a < 'h240)   return {25'h0, m_vec[a - 'h200]};
    return {1'b1, 32'h0};
  endfunction

  // Applies a write to the model, returns the expected error flag
  function automatic bit m_write(input int a, input bit [31:0] d);
    bit hi = a[2];
    bit [63:0] old, c;
    if (a >= 'h20 && a < 'h28) begin
      old = m_mask;
      m_mask = put_half(m_mask, hi, d);
      for (int i = 0; i < 64; i++) if (old[i] && !m_mask[i]) m_up(i);
      for (int i = 0; i < 64; i++) if (!old[i] && m_mask[i]) m_down(i);
      return 0;
    end
    if (a >= 'h40 && a < 'h48) begin m_msgen = put_half(m_msgen, hi, d); return 0; end
    if (a >= 'h60 && a < 'h68) begin m_edge = put_half(m_edge, hi, d); return 0; end
    if (a >= 'h80 && a < 'h88) begin
      c = m_irr & m_edge & (hi ? {d, 32'h0} : {32'h0, d});
      m_irr &= ~c;
      for (int i = 0; i < 64; i++) if (c[i]) m_down(i);
      return 0;
    end
    if ((a >= 'hC0 && a < 'hC8) || (a >= 'hE0 && a < 'hE8) || (a >= 'h3E0 && a < 'h3E8) ||
        (a >= 'h100 && a < 'h140)) return 0;
    if (a >= 'h200 && a < 'h240) begin m_vec[a - 'h200] = d[7:0]; return 0; end
    return 1;
  endfunction

  task automatic bus(input bit wr, input int a, input bit [31:0] d,
                     output bit [31:0] rd, output bit er, output int waited);
    waited = 0;
    @(posedge clk); #1;
    reg_wr = wr; reg_rd = !wr; reg_addr = 10'(a); reg_wdata = d;
    forever begin
      @(negedge clk);
      if (reg_ready) break;
      waited++;
    end
    rd = reg_rdata; er = reg_err;
    @(posedge clk); #1;
    reg_wr = 0; reg_rd = 0;
    @(negedge clk);
    check("R11 ready is a single pulse", reg_ready, 0);
  endtask

  task automatic wr_reg(input string req, input int a, input bit [31:0] d);
    bit [31:0] rd; bit er; int w; bit e_er;
    e_er = m_write(a, d);
    bus(1, a, d, rd, er, w);
    check(req, er, e_er);
  endtask

  task automatic rd_reg(input string req, input int a);
    bit [31:0] rd; bit er; int w; bit [32:0] e;
    e = m_read(a);
    bus(0, a, 0, rd, er, w);
    check(req, {er, rd}, e);
  endtask

  task automatic drive_in(input bit [63:0] v);
    for (int i = 0; i < 64; i++) begin
      if (v[i] && !irq_in[i]) begin m_irr[i] = 1; m_up(i); end
      if (!v[i] && irq_in[i] && !m_edge[i]) begin m_irr[i] = 0; m_down(i); end
    end
    @(posedge clk); #1;
    irq_in = v;
  endtask

  task automatic settle(input string req);
    repeat (220) @(posedge clk);
    check(req, exp_q.size(), 0);
  endtask

  // Event monitor: a handshake seen at negedge completes at the next posedge
  always @(negedge clk) begin
    if (!rst && evt_valid && evt_ready) begin
      if (exp_q.size() == 0) check("R10 unexpected event", {evt_level, evt_vector}, 9'h1FF);
      else check("R10 event order/content", {evt_level, evt_vector}, exp_q.pop_front());
    end
  end

  // Downstream ready driver
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      evt_ready = hold_low ? 1'b0 : (bp_en ? (cyc[0] ^ cyc[2]) : 1'b1);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    bit [31:0] rd; bit er; int w;
    for (int i = 0; i < 64; i++) m_vec[i] = 8'(i);
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check("R12 no event after reset", evt_valid, 0);
    rd_reg("R12 mask low set", 'h20);
    rd_reg("R12 mask high set", 'h24);
    rd_reg("R12 edge clear", 'h60);
    rd_reg("R9 vector reset to index", 'h205);
    rd_reg("R3 ident low", 'h00);
    rd_reg("R3 ident high", 'h04);
    rd_reg("R3 ident high byte 6", 'h06);

    wr_reg("R6 unmask 3:0", 'h20, 32'hFFFF_FFF0);
    settle("R6 no event for idle lines");
    drive_in(64'h0000_0100_0000_0005);
    settle("R4 asserts for lines 0,2 only");
    wr_reg("R6 unmask line 40", 'h24, 32'hFFFF_FEFF);
    settle("R6 assert line 40");
    wr_reg("R6 mask line 0", 'h20, 32'hFFFF_FFF1);
    settle("R6 masking is silent");
    drive_in(64'h0000_0100_0000_0004);
    settle("R5 masked level fall deasserts");
    wr_reg("R9 vector write", 'h202, 32'h1234_56AB);
    rd_reg("R9 vector readback", 'h202);
    drive_in(64'h0000_0100_0000_0000);
    settle("R9 deassert carries new vector");

    wr_reg("R1 edge low", 'h60, 32'h0000_0008);
    drive_in(64'h0000_0100_0000_0008);
    settle("R4 edge line asserts");
    drive_in(64'h0000_0100_0000_0000);
    settle("R5 edge fall ignored");
    wr_reg("R7 clear on level line", 'h84, 32'h0000_0100);
    settle("R7 level line untouched");
    wr_reg("R7 clear edge line", 'h80, 32'h0000_0008);
    settle("R7 clear deasserts");
    drive_in(64'h0);
    settle("R5 level line 40 deasserts");

    wr_reg("R1 edge lines 7:3", 'h60, 32'h0000_00F8);
    drive_in(64'h0000_0000_0000_00F0);
    settle("R4 masked rises silent");
    bp_en = 1;
    wr_reg("R6 unmask four pending", 'h20, 32'hFFFF_FF01);
    settle("R6 four asserts ascending under backpressure");
    wr_reg("R7 clear four", 'h80, 32'h0000_00FF);
    settle("R7 four deasserts");
    bp_en = 0;
    drive_in(64'h0);
    settle("R5 edge falls ignored");

    wr_reg("R1 edge high half", 'h64, 32'h0000_1234);
    rd_reg("R1 low half preserved", 'h60);
    rd_reg("R1 high half written", 'h64);
    rd_reg("R1 mask low", 'h20);

    wr_reg("R8 msg enable", 'h44, 32'hCAFE_F00D);
    rd_reg("R8 msg enable readback", 'h44);
    rd_reg("R8 msg enable low untouched", 'h40);
    wr_reg("R8 auto ctl A", 'hC0, 32'h5);
    rd_reg("R8 auto ctl A reads 0", 'hC0);
    wr_reg("R8 auto ctl B", 'hE4, 32'h7);
    rd_reg("R8 auto ctl B reads 0", 'hE4);
    wr_reg("R8 polarity", 'h3E0, 32'hFFFF_FFFF);
    rd_reg("R8 polarity reads 0", 'h3E0);
    wr_reg("R8 route", 'h105, 32'h0);
    rd_reg("R8 route reads 1", 'h105);

    rd_reg("R2 hole read", 'h10);
    wr_reg("R2 hole write", 'h300, 32'h1);
    rd_reg("R2 clear read refused", 'h80);
    wr_reg("R2 ident write refused", 'h00, 32'h1);
    rd_reg("R2 past polarity", 'h3E8);
    rd_reg("R2 past vector table", 'h240);

    wr_reg("R6 unmask 10:8", 'h20, 32'hFFFF_F801);
    hold_low = 1;
    drive_in(64'h0000_0000_0000_0700);
    fork
      begin
        repeat (30) @(negedge clk);
        hold_low = 0;
      end
      begin
        bit [32:0] e;
        e = m_read('h20);
        bus(0, 'h20, 0, rd, er, w);
        check("R11 read during stall", {er, rd}, e);
        check("R11 stalled while work pending", (w >= 25), 1);
      end
    join
    settle("R10 held events delivered");
    drive_in(64'h0);
    settle("R5 three deasserts");

    finish_up();
  end

endmodule